// File: doc/BRIEF.md
# Pseudo-Static Memory Mode and Control Logic

This block is the device-side control logic of an asynchronous 16-bit pseudo-static memory. It is clocked with synchronous active-high reset and works on sampled pin levels. Each cycle it classifies the active-low controls into one of six access kinds: chip select, write strobe, read strobe, upper and lower lane selects, and the sleep pin. It registers the kind together with per-lane array write strobes, per-lane data-drive enables and an out-of-range flag. The storage array and the refresh engine sit outside. They consume the strobes and the two address windows that this block reports.

A 5-bit mode register is loaded from the five low address bits by a write cycle made while the sleep pin is low. The register selects three behaviours. The first is a shrunken usable address window, which becomes live when the sleep pin next goes high. The second is a reduced refresh window, which applies only while the sleep pin is low. The third is a deep-sleep state that stops refresh and restores every mode bit to its default when the sleep pin is released.

Top module: `psram_ctl`

## Requirements
- R1: With the sleep pin high, a high chip select or both lane selects high gives access code 0 (idle), with no write strobe and no lane driven, whatever the other controls are.
- R2: Chip select low and write strobe low (sleep high, a lane selected) gives access code 2 (write): the read strobe is ignored and no lane is driven.
- R3: Chip select low, write strobe high and read strobe low gives access code 1 (read), with the selected lanes driven. With the read strobe high the code is 3 (hold) and nothing is driven.
- R4: Bit 0 of the strobe and drive outputs belongs to the lower lane (data 7:0, lower select), and bit 1 belongs to the upper lane (data 15:8, upper select).
- R5: With the sleep pin low the code is 5 (mode load) when chip select, write strobe and a lane select are all low, and 4 (nap) otherwise. The mode register takes address bits 4:0 only on code 5, and higher address bits have no effect on it.
- R6: Mode bit 4 is 0 for deep sleep (default 1). Bit 3 is 1 for shrink and 0 for partial refresh (default 0). Bit 2 is 1 for top and 0 for bottom (default 0). Bits 1:0 give the window size: 11 is a quarter, 10 is a half, and 00 or 01 is the full space. The windows in words are 000000h-07FFFFh, 000000h-0FFFFFh, 180000h-1FFFFFh, 100000h-1FFFFFh and 000000h-1FFFFFh.
- R7: The usable window follows the mode register copied at the sleep pin's rising edge. It is the R6 window when that copy has bit 3 set, and the full space otherwise, and it stays so until the next rising edge.
- R8: The refresh window is the R6 window of the mode register while the sleep pin is low with bit 3 clear and bit 4 set. At all other times it is the full space.
- R9: While the sleep pin is low with mode bit 4 clear, the deep-sleep flag is 1 and refresh enable is 0. The rising edge that ends it resets the mode register and the usable-window copy to 10000b.
- R10: A read or write outside the usable window raises the out-of-range flag and produces no strobe and no drive.
- R11: After reset the access code is 0, the mode register is 10000b, both windows are the full space, refresh is enabled and deep sleep is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| ub_n | input | 1 | Upper lane select, active low |
| lb_n | input | 1 | Lower lane select, active low |
| sleep_n | input | 1 | Low-power pin, active low |
| addr | input | AW | Word address |
| acc_kind | output | 3 | Registered access code (R1-R5 codes) |
| mem_we | output | 2 | Per-lane array write strobes |
| dq_oe | output | 2 | Per-lane data drive enables |
| oor | output | 1 | Out-of-range access flag |
| cfg_o | output | 5 | Mode register contents |
| use_lo | output | AW | Lowest usable word |
| use_hi | output | AW | Highest usable word |
| rfsh_lo | output | AW | Lowest refreshed word |
| rfsh_hi | output | AW | Highest refreshed word |
| rfsh_en | output | 1 | Refresh enabled |
| deep_sleep | output | 1 | Deep-sleep state |

## Verification
The sleep pin's rising edge can coincide with an access, and two things then happen in the same clock: the usable window is replaced, and the access is range-checked against the window that was live before that edge. Random sequences toggle the sleep pin often and mix in mode loads, so a wake cycle regularly carries a read or write. Directed sequences place accesses on both sides of a shrunken window's boundary. A bench model updates its own window only after judging the access, and every output is compared after each edge. A deep-sleep exit that falls in the same cycle as a wake-time copy is judged the same way, and the defaults must win.

// File: rtl/psram_ctl_pkg.sv
package psram_ctl_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE  = 3'd0,
        ACC_READ  = 3'd1,
        ACC_WRITE = 3'd2,
        ACC_HOLD  = 3'd3,
        ACC_NAP   = 3'd4,
        ACC_CFG   = 3'd5
    } acc_e;

    typedef struct packed {
        logic       keep_n;   // 0 = deep sleep when pin low
        logic       shrink;   // 1 = shrunken usable window
        logic       top;      // 1 = upper part of the space
        logic [1:0] size;     // 11 quarter, 10 half, else full
    } cfg_t;

    localparam cfg_t CFG_DEF = '{keep_n: 1'b1, shrink: 1'b0, top: 1'b0, size: 2'b00};

    function automatic logic [31:0] span_words(cfg_t c, int aw);
        logic [31:0] full;
        full = 32'd1 << aw;
        case (c.size)
            2'b11:   return full >> 2;
            2'b10:   return full >> 1;
            default: return full;
        endcase
    endfunction

    function automatic logic [31:0] span_lo(cfg_t c, int aw);
        return c.top ? (32'd1 << aw) - span_words(c, aw) : 32'd0;
    endfunction

    function automatic logic [31:0] span_hi(cfg_t c, int aw);
        return span_lo(c, aw) + span_words(c, aw) - 32'd1;
    endfunction

endpackage

// File: rtl/psram_cmd_decode.sv
module psram_cmd_decode
    import psram_ctl_pkg::*;
(
    input  logic       cs_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       ub_n,
    input  logic       lb_n,
    input  logic       sleep_n,
    output acc_e       acc,
    output logic [1:0] lanes
);
    logic no_lane;

    assign no_lane = ub_n & lb_n;
    assign lanes   = ~{ub_n, lb_n};

    always_comb begin
        if (!sleep_n) begin
            acc = (!cs_n && !we_n && !no_lane) ? ACC_CFG : ACC_NAP;
        end else if (cs_n || no_lane) begin
            acc = ACC_IDLE;
        end else if (!we_n) begin
            acc = ACC_WRITE;
        end else if (!oe_n) begin
            acc = ACC_READ;
        end else begin
            acc = ACC_HOLD;
        end
    end
endmodule

// File: rtl/psram_mode_reg.sv
module psram_mode_reg
    import psram_ctl_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_n,
    input  logic          cfg_wr,
    input  cfg_t          cfg_din,
    output cfg_t          cfg_q,
    output logic          rms_on,
    output logic [AW-1:0] use_lo,
    output logic [AW-1:0] use_hi,
    output logic [AW-1:0] rfsh_lo,
    output logic [AW-1:0] rfsh_hi,
    output logic          rfsh_en,
    output logic          deep_sleep
);
    cfg_t live_q;
    cfg_t use_sel;
    cfg_t rf_sel;
    logic sleep_q;
    logic wake;
    logic par_on;

    assign wake = sleep_n & ~sleep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_DEF;
            live_q  <= CFG_DEF;
            sleep_q <= 1'b1;
        end else begin
            sleep_q <= sleep_n;
            if (cfg_wr) begin
                cfg_q <= cfg_din;
            end else if (wake) begin
                if (!cfg_q.keep_n) begin
                    cfg_q  <= CFG_DEF;
                    live_q <= CFG_DEF;
                end else begin
                    live_q <= cfg_q;
                end
            end
        end
    end

    assign deep_sleep = ~sleep_q & ~cfg_q.keep_n;
    assign rfsh_en    = ~deep_sleep;
    assign par_on     = ~sleep_q & ~cfg_q.shrink & cfg_q.keep_n;
    assign rms_on     = live_q.shrink;
    assign use_sel    = live_q.shrink ? live_q : CFG_DEF;
    assign rf_sel     = par_on ? cfg_q : CFG_DEF;
    assign use_lo     = AW'(span_lo(use_sel, AW));
    assign use_hi     = AW'(span_hi(use_sel, AW));
    assign rfsh_lo    = AW'(span_lo(rf_sel, AW));
    assign rfsh_hi    = AW'(span_hi(rf_sel, AW));

    // R9: leaving deep sleep restores the defaults
    p_deep_exit_default_r9: assert property (@(posedge clk) disable iff (rst)
        (!sleep_q && !cfg_q.keep_n && sleep_n) |=> (cfg_q == CFG_DEF && !rms_on));

    // R7: a wake without deep sleep copies the mode register
    p_wake_copy_r7: assert property (@(posedge clk) disable iff (rst)
        (!sleep_q && cfg_q.keep_n && sleep_n) |=> (rms_on == $past(cfg_q.shrink)));

    // R9: no refresh in deep sleep
    p_deep_no_refresh_r9: assert property (@(posedge clk) disable iff (rst)
        deep_sleep |-> !rfsh_en);

    // R6: windows are well ordered
    p_span_order_r6: assert property (@(posedge clk) disable iff (rst)
        (use_lo <= use_hi) && (rfsh_lo <= rfsh_hi));
endmodule

// File: rtl/psram_access_gate.sv
module psram_access_gate
    import psram_ctl_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_e          acc,
    input  logic [1:0]    lanes,
    input  logic [AW-1:0] addr,
    input  logic          rms_on,
    input  logic [AW-1:0] use_lo,
    input  logic [AW-1:0] use_hi,
    output acc_e          acc_q,
    output logic [1:0]    mem_we,
    output logic [1:0]    dq_oe,
    output logic          oor
);
    logic is_rw;
    logic miss;

    assign is_rw = (acc == ACC_READ) || (acc == ACC_WRITE);
    assign miss  = rms_on && ((addr < use_lo) || (addr > use_hi));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= ACC_IDLE;
            mem_we <= '0;
            dq_oe  <= '0;
            oor    <= 1'b0;
        end else begin
            acc_q  <= acc;
            oor    <= is_rw && miss;
            mem_we <= (acc == ACC_WRITE && !miss) ? lanes : 2'b00;
            dq_oe  <= (acc == ACC_READ && !miss) ? lanes : 2'b00;
        end
    end

    // R1: idle cycles touch nothing
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_IDLE) |-> (mem_we == 2'b00 && dq_oe == 2'b00));

    // R2: a write never drives the data lanes
    p_write_no_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_we != 2'b00) |-> (dq_oe == 2'b00 && acc_q == ACC_WRITE));

    // R10: an out-of-range access is fully suppressed
    p_oor_suppress_r10: assert property (@(posedge clk) disable iff (rst)
        oor |-> (mem_we == 2'b00 && dq_oe == 2'b00));
endmodule

// File: rtl/psram_ctl.sv
module psram_ctl
    import psram_ctl_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          ub_n,
    input  logic          lb_n,
    input  logic          sleep_n,
    input  logic [AW-1:0] addr,
    output logic [2:0]    acc_kind,
    output logic [1:0]    mem_we,
    output logic [1:0]    dq_oe,
    output logic          oor,
    output logic [4:0]    cfg_o,
    output logic [AW-1:0] use_lo,
    output logic [AW-1:0] use_hi,
    output logic [AW-1:0] rfsh_lo,
    output logic [AW-1:0] rfsh_hi,
    output logic          rfsh_en,
    output logic          deep_sleep
);
    acc_e       acc;
    acc_e       acc_q;
    logic [1:0] lanes;
    cfg_t       cfg_q;
    logic       rms_on;

    psram_cmd_decode u_dec (
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n),
        .sleep_n(sleep_n), .acc(acc), .lanes(lanes)
    );

    psram_mode_reg #(.AW(AW)) u_mode (
        .clk(clk), .rst(rst), .sleep_n(sleep_n),
        .cfg_wr(acc == ACC_CFG), .cfg_din(cfg_t'(addr[4:0])),
        .cfg_q(cfg_q), .rms_on(rms_on),
        .use_lo(use_lo), .use_hi(use_hi),
        .rfsh_lo(rfsh_lo), .rfsh_hi(rfsh_hi),
        .rfsh_en(rfsh_en), .deep_sleep(deep_sleep)
    );

    psram_access_gate #(.AW(AW)) u_gate (
        .clk(clk), .rst(rst), .acc(acc), .lanes(lanes), .addr(addr),
        .rms_on(rms_on), .use_lo(use_lo), .use_hi(use_hi),
        .acc_q(acc_q), .mem_we(mem_we), .dq_oe(dq_oe), .oor(oor)
    );

    assign acc_kind = acc_q;
    assign cfg_o    = cfg_q;
endmodule

// File: tb/psram_ctl_bench.sv
module psram_ctl_bench;
    localparam int AW = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1, sleep_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [2:0]    acc_kind;
    logic [1:0]    mem_we, dq_oe;
    logic          oor, rfsh_en, deep_sleep;
    logic [4:0]    cfg_o;
    logic [AW-1:0] use_lo, use_hi, rfsh_lo, rfsh_hi;

    int n_checks = 0;
    int n_fail   = 0;

    logic [4:0] m_cfg  = 5'b10000;
    logic [4:0] m_live = 5'b10000;
    logic       m_sq   = 1'b1;

    always #4 clk = ~clk;

    psram_ctl #(.AW(AW)) u_psram_ctl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .sleep_n(sleep_n), .addr(addr),
        .acc_kind(acc_kind), .mem_we(mem_we), .dq_oe(dq_oe), .oor(oor),
        .cfg_o(cfg_o), .use_lo(use_lo), .use_hi(use_hi),
        .rfsh_lo(rfsh_lo), .rfsh_hi(rfsh_hi), .rfsh_en(rfsh_en),
        .deep_sleep(deep_sleep)
    );

    function automatic logic [41:0] win(logic [4:0] c);
        logic [20:0] lo, hi;
        case (c[1:0])
            2'b11:   begin lo = c[2] ? 21'h180000 : 21'h000000; hi = c[2] ? 21'h1FFFFF : 21'h07FFFF; end
            2'b10:   begin lo = c[2] ? 21'h100000 : 21'h000000; hi = c[2] ? 21'h1FFFFF : 21'h0FFFFF; end
            default: begin lo = 21'h000000; hi = 21'h1FFFFF; end
        endcase
        return {lo, hi};
    endfunction

    function automatic logic [2:0] exp_acc(logic cs, logic we, logic oe, logic ub, logic lb, logic sl);
        if (!sl)            return (!cs && !we && !(ub && lb)) ? 3'd5 : 3'd4;
        if (cs || (ub && lb)) return 3'd0;
        if (!we)            return 3'd2;
        if (!oe)            return 3'd1;
        return 3'd3;
    endfunction

    function automatic logic [108:0] actual();
        return {acc_kind, mem_we, dq_oe, oor, cfg_o, use_lo, use_hi, rfsh_lo, rfsh_hi, rfsh_en, deep_sleep};
    endfunction

    task automatic step(input logic cs, input logic we, input logic oe, input logic ub,
                        input logic lb, input logic sl, input logic [20:0] a, input string tag);
        logic [2:0]  e_acc;
        logic        e_oor;
        logic [1:0]  e_we, e_oe, ln;
        logic [41:0] uw, rw;
        logic        deep;
        logic [108:0] exp_v;
        cs_n = cs; we_n = we; oe_n = oe; ub_n = ub; lb_n = lb; sleep_n = sl; addr = a;
        e_acc = exp_acc(cs, we, oe, ub, lb, sl);
        ln    = ~{ub, lb};
        uw    = m_live[3] ? win(m_live) : win(5'b10000);
        e_oor = (e_acc == 3'd1 || e_acc == 3'd2) && m_live[3] && (a < uw[41:21] || a > uw[20:0]);
        e_we  = (e_acc == 3'd2 && !e_oor) ? ln : 2'b00;
        e_oe  = (e_acc == 3'd1 && !e_oor) ? ln : 2'b00;
        if (e_acc == 3'd5) m_cfg = a[4:0];
        else if (sl && !m_sq) begin
            if (!m_cfg[4]) begin m_cfg = 5'b10000; m_live = 5'b10000; end
            else m_live = m_cfg;
        end
        m_sq = sl;
        deep = !m_sq && !m_cfg[4];
        uw = m_live[3] ? win(m_live) : win(5'b10000);
        rw = (!m_sq && !m_cfg[3] && m_cfg[4]) ? win(m_cfg) : win(5'b10000);
        exp_v = {e_acc, e_we, e_oe, e_oor, m_cfg, uw, rw, !deep, deep};
        @(posedge clk);
        #1;
        n_checks++;
        if (actual() !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, actual(), exp_v);
        end
    endtask

    task automatic load_cfg(input logic [4:0] v, input logic [15:0] upper, input string tag);
        step(1, 1, 1, 1, 1, 0, 21'h0, tag);
        step(0, 0, 1, 0, 1, 0, {upper, v}, tag);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5A17);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        n_checks++;
        if (actual() !== {3'd0, 2'b00, 2'b00, 1'b0, 5'b10000, 21'h0, 21'h1FFFFF, 21'h0, 21'h1FFFFF, 1'b1, 1'b0}) begin
            n_fail++;
            $display("FAIL R11 reset: actual %h expected idle defaults", actual());
        end

        step(1, 0, 0, 0, 0, 1, 21'h12345, "R1 cs high");
        step(0, 0, 0, 1, 1, 1, 21'h12345, "R1 no lane");
        step(0, 0, 0, 0, 0, 1, 21'h00010, "R2 write oe low ignored");
        step(0, 0, 1, 1, 0, 1, 21'h00011, "R4 write lower lane");
        step(0, 1, 0, 0, 1, 1, 21'h00012, "R3 R4 read upper lane");
        step(0, 1, 1, 0, 0, 1, 21'h00013, "R3 hold");
        load_cfg(5'b11111, 16'hFFFF, "R5 load upper bits ignored");
        step(0, 1, 0, 0, 0, 0, 21'h0, "R8 nap shrink mode full refresh");
        step(1, 1, 1, 1, 1, 1, 21'h0, "R7 wake applies top quarter");
        step(0, 1, 0, 0, 0, 1, 21'h000000, "R10 read below window");
        step(0, 0, 1, 0, 0, 1, 21'h180000, "R10 write at window start");
        step(0, 0, 1, 0, 0, 1, 21'h17FFFF, "R10 write below window");
        step(0, 1, 0, 0, 0, 1, 21'h1FFFFF, "R10 read at window end");
        load_cfg(5'b10010, 16'h0000, "R8 partial bottom half");
        step(1, 1, 1, 1, 1, 0, 21'h0, "R8 refresh bottom half in nap");
        step(0, 1, 0, 0, 0, 1, 21'h000000, "R7 wake drops shrink");
        step(1, 1, 1, 1, 1, 1, 21'h0, "R8 refresh full when awake");
        load_cfg(5'b11101, 16'h0000, "R6 reserved size");
        step(1, 1, 1, 1, 1, 1, 21'h0, "R6 reserved size full window");
        load_cfg(5'b10110, 16'h0000, "R6 top half partial");
        step(1, 1, 1, 1, 1, 0, 21'h0, "R6 top half refresh");
        load_cfg(5'b01111, 16'h0000, "R9 deep sleep entry");
        step(1, 1, 1, 1, 1, 0, 21'h0, "R9 deep sleep holds");
        step(0, 0, 1, 0, 0, 1, 21'h0, "R9 exit restores defaults");
        step(1, 1, 1, 1, 1, 1, 21'h0, "R9 defaults after exit");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic [20:0] a;
            r = $urandom;
            a = 21'($urandom);
            if (r[3:0] == 4'd0 && r[4]) a[4:0] = {1'b1, r[7], r[8], 2'b1} | 5'b00010;
            step(r[9] & r[10], r[11], r[12], r[13] & r[14], r[15] & r[16],
                 |r[19:17], a, "R1 R2 R3 R5 R7 R10 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule